// File: doc/BRIEF.md
# Ring Node Frame Receiver

This block sits at the input of one node on a token-passing control ring. The link has two wires: a forwarded clock and an NRZI-coded data line. Because the clock travels with the data, the receiver samples the data line on that clock and needs no clock recovery. After decoding the line, the receiver hunts bit by bit for the start-of-frame code. Once it finds it, it cuts the stream into bytes and walks the frame: destination, source, length, data bytes, a 16-bit CRC and an end-of-frame code. A short start / token / end sequence passes the right to transmit and is reported on its own.

The node keeps a frame only if the destination field carries the node's own 7-bit address or the broadcast address. The data bytes of a kept frame come out as a byte stream. The first two data bytes are also latched as the channel number and the transaction number. Four one-cycle flags report the outcome of each frame: accepted, CRC error, illegal sequence and token. At most one of them is raised at a time.

Top module: `ring_frame_rx`

## Requirements
- R1: The data line is NRZI decoded on every rising clock edge. A level change since the previous sample is a 1 and an unchanged level is a 0. Bytes arrive most significant bit first.
- R2: While unlocked, the receiver compares the last eight decoded bits with the start code 0x7E after every bit. On a match it locks, and from then on each further group of eight bits forms one byte.
- R3: After the start code, byte 1 carries the destination in bits 6:0, byte 2 the source in bits 6:0, and byte 3 the count of data bytes. These appear on `dest_addr`, `src_addr` and `frame_len`.
- R4: The first data byte is latched on `chan_num` and the second on `trans_num`. Both read 0 when the frame has fewer data bytes.
- R5: The CRC uses polynomial 0x1021, is preset to 0xFFFF and covers the destination through the last data byte. It is sent high byte first after the data and is followed by the end code 0x3C. `frame_ok` pulses for one clock when the CRC, the length and the address all check.
- R6: If the CRC does not match and the end code arrives in its proper place, `crc_err` pulses for one clock and `frame_ok` stays low.
- R7: A frame counts as addressed when its destination equals `node_addr` or 0x7F. `is_bcast` is high with `frame_ok` when the destination is 0x7F. A frame addressed to another node gives neither `frame_ok` nor payload.
- R8: If the end code arrives before or after the place set by the length field, `illegal_seq` pulses and the frame is dropped. The next frame is received normally.
- R9: The sequence start, token code 0xE7, end pulses `token_seen`. A token code followed by anything other than the end code pulses `illegal_seq`.
- R10: A start code in the middle of a frame pulses `illegal_seq` and opens a new frame at that start code.
- R11: Each data byte of an addressed frame appears once on `pay_data`, in order, with `pay_valid` high for one clock.
- R12: During reset all flags and all field outputs are 0.
- R13: `frame_ok`, `crc_err`, `illegal_seq` and `token_seen` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Forwarded link clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | NRZI-coded data line |
| node_addr | input | 7 | This node's address |
| dest_addr | output | 7 | Destination of the latest frame |
| src_addr | output | 7 | Source of the latest frame |
| frame_len | output | 8 | Length field of the latest frame |
| chan_num | output | 8 | First data byte |
| trans_num | output | 8 | Second data byte |
| is_bcast | output | 1 | Destination was the broadcast address |
| pay_data | output | 8 | Payload byte |
| pay_valid | output | 1 | Payload byte strobe |
| frame_ok | output | 1 | Frame accepted pulse |
| crc_err | output | 1 | CRC mismatch pulse |
| illegal_seq | output | 1 | Malformed delimiter or length pulse |
| token_seen | output | 1 | Token received pulse |

## Verification
Two events can fall on the same byte strobe: the illegal-sequence report for an unfinished frame, and the opening of a new frame by a repeated start code. The bench provokes this by cutting a frame short after its source byte and sending a complete frame straight behind it. It then expects exactly one illegal pulse, followed by a normal acceptance of the second frame with its full payload. Beyond that case, a sweep over node address, destination class and every length from 0 to 6 compares all fields and payload bytes with a CRC computed bit by bit in the bench.

// File: rtl/ring_rx_pkg.sv
`timescale 1ns/1ps
package ring_rx_pkg;
  localparam logic [7:0] SOF_CODE   = 8'h7E;
  localparam logic [7:0] EOF_CODE   = 8'h3C;
  localparam logic [7:0] TOK_CODE   = 8'hE7;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;

  typedef enum logic [2:0] {
    PS_IDLE, PS_FIRST, PS_TOKEND, PS_SRC, PS_LEN, PS_DATA, PS_CRC, PS_END
  } rx_state_e;

  // one byte of CRC x^16+x^12+x^5+1, msb first, byte-parallel form
  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
    logic [7:0] x;
    x = c[15:8] ^ d;
    x = x ^ (x >> 4);
    return {c[7:0], 8'h00} ^ ({8'h00, x} << 12) ^ ({8'h00, x} << 5) ^ {8'h00, x};
  endfunction

  function automatic logic is_delim(input logic [7:0] b);
    return (b == SOF_CODE) || (b == EOF_CODE) || (b == TOK_CODE);
  endfunction
endpackage

// File: rtl/nrzi_decoder.sv
`timescale 1ns/1ps
module nrzi_decoder (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic bit_o
);
  logic line_q;

  always_ff @(posedge clk) line_q <= line_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_o <= 1'b0;
    else        bit_o <= line_i ^ line_q;
  end

  AST_NRZI_STEADY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(line_i) |=> !bit_o); // R1
endmodule

// File: rtl/byte_aligner.sv
`timescale 1ns/1ps
module byte_aligner import ring_rx_pkg::*; #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_i,
  input  logic              unlock_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              stb_o
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh_q, sh_nxt;
  logic [CNT_W-1:0]  cnt_q;
  logic              locked_q;
  logic              sync_hit;

  assign sh_nxt   = {sh_q[BYTE_W-2:0], bit_i};
  assign sync_hit = (sh_nxt == BYTE_W'(SOF_CODE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      locked_q <= 1'b0;
      stb_o    <= 1'b0;
      byte_o   <= '0;
    end else begin
      sh_q  <= sh_nxt;
      stb_o <= 1'b0;
      if (unlock_i) begin
        locked_q <= 1'b0;
        cnt_q    <= '0;
      end else if (!locked_q) begin
        if (sync_hit) begin
          locked_q <= 1'b1;
          cnt_q    <= '0;
          stb_o    <= 1'b1;
          byte_o   <= sh_nxt;
        end
      end else if (cnt_q == LAST) begin
        cnt_q  <= '0;
        stb_o  <= 1'b1;
        byte_o <= sh_nxt;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_LOCK_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> (stb_o && byte_o == BYTE_W'(SOF_CODE))); // R2
endmodule

// File: rtl/crc16_acc.sv
`timescale 1ns/1ps
module crc16_acc import ring_rx_pkg::*; #(
  parameter int CRC_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_i,
  input  logic       upd_i,
  input  logic [7:0] byte_i,
  output logic       zero_o
);
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= CRC_PRESET;
    else if (init_i) crc_q <= CRC_PRESET;
    else if (upd_i)  crc_q <= crc16_byte(crc_q, byte_i);
  end

  assign zero_o = (crc_q == '0);

  AST_CRC_INIT_UPD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(init_i && upd_i)); // R5
endmodule

// File: rtl/frame_parser.sv
`timescale 1ns/1ps
module frame_parser import ring_rx_pkg::*; #(
  parameter int ADDR_W = 7,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_i,
  input  logic [7:0]        byte_i,
  input  logic [ADDR_W-1:0] node_addr_i,
  input  logic              crc_zero_i,
  output logic              crc_init_o,
  output logic              crc_upd_o,
  output logic              unlock_o,
  output logic [ADDR_W-1:0] dest_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [7:0]        chan_o,
  output logic [7:0]        trans_o,
  output logic              bcast_o,
  output logic [7:0]        pay_data_o,
  output logic              pay_valid_o,
  output logic              ok_o,
  output logic              crc_err_o,
  output logic              illegal_o,
  output logic              token_o
);
  localparam logic [ADDR_W-1:0] BCAST = '1;

  rx_state_e        st_q, st_nxt;
  logic [LEN_W-1:0] cnt_q;
  logic             crc_idx_q;
  logic             hit_q;
  logic             b_sof, b_eof, b_tok, b_delim;
  logic             ev_ok, ev_crc, ev_ill, ev_tok;
  logic [ADDR_W-1:0] b_addr;
  logic             b_match;

  assign b_sof   = (byte_i == SOF_CODE);
  assign b_eof   = (byte_i == EOF_CODE);
  assign b_tok   = (byte_i == TOK_CODE);
  assign b_delim = is_delim(byte_i);
  assign b_addr  = byte_i[ADDR_W-1:0];
  assign b_match = (b_addr == node_addr_i) || (b_addr == BCAST);

  always_comb begin
    st_nxt = st_q;
    ev_ok  = 1'b0;
    ev_crc = 1'b0;
    ev_ill = 1'b0;
    ev_tok = 1'b0;
    if (stb_i) begin
      if (b_sof) begin
        st_nxt = PS_FIRST;
        ev_ill = (st_q != PS_IDLE);
      end else begin
        case (st_q)
          PS_IDLE:   st_nxt = PS_IDLE;
          PS_FIRST: begin
            if (b_tok)        st_nxt = PS_TOKEND;
            else if (b_delim) begin ev_ill = 1'b1; st_nxt = PS_IDLE; end
            else              st_nxt = PS_SRC;
          end
          PS_TOKEND: begin
            if (b_eof) ev_tok = 1'b1;
            else       ev_ill = 1'b1;
            st_nxt = PS_IDLE;
          end
          PS_SRC: begin
            if (b_delim) begin ev_ill = 1'b1; st_nxt = PS_IDLE; end
            else         st_nxt = PS_LEN;
          end
          PS_LEN: begin
            if (b_delim)          begin ev_ill = 1'b1; st_nxt = PS_IDLE; end
            else if (byte_i == 0) st_nxt = PS_CRC;
            else                  st_nxt = PS_DATA;
          end
          PS_DATA: begin
            if (b_delim)                         begin ev_ill = 1'b1; st_nxt = PS_IDLE; end
            else if (cnt_q == len_o - LEN_W'(1)) st_nxt = PS_CRC;
          end
          PS_CRC: begin
            if (b_delim)        begin ev_ill = 1'b1; st_nxt = PS_IDLE; end
            else if (crc_idx_q) st_nxt = PS_END;
          end
          PS_END: begin
            if (b_eof) begin
              if (crc_zero_i) ev_ok  = hit_q;
              else            ev_crc = 1'b1;
            end else begin
              ev_ill = 1'b1;
            end
            st_nxt = PS_IDLE;
          end
          default: st_nxt = PS_IDLE;
        endcase
      end
    end
  end

  assign unlock_o   = stb_i && (st_nxt == PS_IDLE);
  assign crc_init_o = stb_i && b_sof;
  assign crc_upd_o  = stb_i && !b_delim &&
                      (st_q inside {PS_FIRST, PS_SRC, PS_LEN, PS_DATA, PS_CRC});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= PS_IDLE;
      cnt_q       <= '0;
      crc_idx_q   <= 1'b0;
      hit_q       <= 1'b0;
      dest_o      <= '0;
      src_o       <= '0;
      len_o       <= '0;
      chan_o      <= '0;
      trans_o     <= '0;
      bcast_o     <= 1'b0;
      pay_data_o  <= '0;
      pay_valid_o <= 1'b0;
      ok_o        <= 1'b0;
      crc_err_o   <= 1'b0;
      illegal_o   <= 1'b0;
      token_o     <= 1'b0;
    end else begin
      st_q        <= st_nxt;
      ok_o        <= ev_ok;
      crc_err_o   <= ev_crc;
      illegal_o   <= ev_ill;
      token_o     <= ev_tok;
      pay_valid_o <= 1'b0;
      if (stb_i) begin
        if (b_sof) begin
          hit_q   <= 1'b0;
          chan_o  <= '0;
          trans_o <= '0;
          cnt_q   <= '0;
        end else if (!b_delim) begin
          case (st_q)
            PS_FIRST: begin
              dest_o  <= b_addr;
              hit_q   <= b_match;
              bcast_o <= (b_addr == BCAST);
            end
            PS_SRC: src_o <= b_addr;
            PS_LEN: begin
              len_o     <= LEN_W'(byte_i);
              cnt_q     <= '0;
              crc_idx_q <= 1'b0;
            end
            PS_DATA: begin
              if (cnt_q == LEN_W'(0)) chan_o  <= byte_i;
              if (cnt_q == LEN_W'(1)) trans_o <= byte_i;
              cnt_q       <= cnt_q + 1'b1;
              pay_data_o  <= byte_i;
              pay_valid_o <= hit_q;
            end
            PS_CRC: crc_idx_q <= 1'b1;
            default: ;
          endcase
        end
      end
    end
  end

  AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ok_o, crc_err_o, illegal_o, token_o})); // R13
  AST_OK_ADDRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    ok_o |-> (dest_o == node_addr_i || dest_o == BCAST)); // R7
  AST_OK_CRC_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    ok_o |-> $past(crc_zero_i)); // R5
  AST_CRCERR_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err_o |-> !$past(crc_zero_i)); // R6
  AST_PAY_ADDRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid_o |-> (dest_o == node_addr_i || dest_o == BCAST)); // R11
  AST_PAY_WITHIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid_o |-> (cnt_q != '0 && cnt_q <= len_o)); // R8
endmodule

// File: rtl/ring_frame_rx.sv
`timescale 1ns/1ps
module ring_frame_rx #(
  parameter int ADDR_W = 7,
  parameter int LEN_W  = 8,
  parameter int BYTE_W = 8,
  parameter int CRC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic [ADDR_W-1:0] node_addr,
  output logic [ADDR_W-1:0] dest_addr,
  output logic [ADDR_W-1:0] src_addr,
  output logic [LEN_W-1:0]  frame_len,
  output logic [7:0]        chan_num,
  output logic [7:0]        trans_num,
  output logic              is_bcast,
  output logic [7:0]        pay_data,
  output logic              pay_valid,
  output logic              frame_ok,
  output logic              crc_err,
  output logic              illegal_seq,
  output logic              token_seen
);
  logic              dec_bit;
  logic [BYTE_W-1:0] al_byte;
  logic              al_stb;
  logic              unlock;
  logic              crc_init, crc_upd, crc_zero;

  nrzi_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .line_i(rx_line), .bit_o(dec_bit)
  );

  byte_aligner #(.BYTE_W(BYTE_W)) u_align (
    .clk(clk), .rst_n(rst_n), .bit_i(dec_bit), .unlock_i(unlock),
    .byte_o(al_byte), .stb_o(al_stb)
  );

  crc16_acc #(.CRC_W(CRC_W)) u_crc (
    .clk(clk), .rst_n(rst_n), .init_i(crc_init), .upd_i(crc_upd),
    .byte_i(al_byte), .zero_o(crc_zero)
  );

  frame_parser #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_parse (
    .clk(clk), .rst_n(rst_n), .stb_i(al_stb), .byte_i(al_byte),
    .node_addr_i(node_addr), .crc_zero_i(crc_zero),
    .crc_init_o(crc_init), .crc_upd_o(crc_upd), .unlock_o(unlock),
    .dest_o(dest_addr), .src_o(src_addr), .len_o(frame_len),
    .chan_o(chan_num), .trans_o(trans_num), .bcast_o(is_bcast),
    .pay_data_o(pay_data), .pay_valid_o(pay_valid),
    .ok_o(frame_ok), .crc_err_o(crc_err), .illegal_o(illegal_seq),
    .token_o(token_seen)
  );
endmodule

// File: tb/ring_frame_rx_test.sv
`timescale 1ns/1ps
module ring_frame_rx_test;
  localparam logic [7:0] C_SOF = 8'h7E;
  localparam logic [7:0] C_EOF = 8'h3C;
  localparam logic [7:0] C_TOK = 8'hE7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_line = 1'b0;
  logic [6:0] node_addr = 7'h05;
  logic [6:0] dest_addr, src_addr;
  logic [7:0] frame_len, chan_num, trans_num, pay_data;
  logic is_bcast, pay_valid, frame_ok, crc_err, illegal_seq, token_seen;

  always #2.5 clk = ~clk;

  ring_frame_rx uut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .node_addr(node_addr),
    .dest_addr(dest_addr), .src_addr(src_addr), .frame_len(frame_len),
    .chan_num(chan_num), .trans_num(trans_num), .is_bcast(is_bcast),
    .pay_data(pay_data), .pay_valid(pay_valid), .frame_ok(frame_ok),
    .crc_err(crc_err), .illegal_seq(illegal_seq), .token_seen(token_seen)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor, sampled on the falling edge
  int ok_n, crc_n, ill_n, tok_n, ovl_n, pay_n;
  logic [7:0] pay_buf [0:39];
  logic [6:0] c_dest, c_src;
  logic [7:0] c_len, c_chan, c_trans;
  logic c_bcast;

  always @(negedge clk) if (rst_n) begin
    if (frame_ok) begin
      ok_n++; c_dest = dest_addr; c_src = src_addr; c_len = frame_len;
      c_chan = chan_num; c_trans = trans_num; c_bcast = is_bcast;
    end
    if (crc_err) crc_n++;
    if (illegal_seq) ill_n++;
    if (token_seen) tok_n++;
    if (int'(frame_ok) + int'(crc_err) + int'(illegal_seq) + int'(token_seen) > 1) ovl_n++;
    if (pay_valid) begin
      if (pay_n < 40) pay_buf[pay_n] = pay_data;
      pay_n++;
    end
  end

  task automatic clear();
    #1;
    ok_n = 0; crc_n = 0; ill_n = 0; tok_n = 0; pay_n = 0;
  endtask

  task automatic send_bit(input bit b);
    @(negedge clk);
    if (b) rx_line = ~rx_line;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0);
  endtask

  function automatic bit is_code(input logic [7:0] v);
    return v == C_SOF || v == C_EOF || v == C_TOK;
  endfunction

  function automatic logic [7:0] dbyte(input int seed, input int k);
    logic [7:0] v;
    v = 8'(seed * 29 + k * 53 + 7);
    if (is_code(v)) v = v ^ 8'h01;
    return v;
  endfunction

  // bit-serial shift form of the CRC, msb first
  function automatic logic [15:0] crc_bits(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic fbk;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fbk = r[15] ^ d[i];
      r = {r[14:0], 1'b0};
      if (fbk) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  logic [7:0] fb [0:39];
  int fn;
  logic [6:0] used_src;

  function automatic bit seq_clean();
    logic [7:0] w;
    w = 8'h00;
    for (int i = 1; i < fn - 1; i++) if (is_code(fb[i])) return 1'b0;
    for (int i = 1; i <= fn; i++)
      for (int j = 7; j >= 0; j--) begin
        w = {w[6:0], (i < fn) ? fb[i][j] : 1'b0};
        if (w == C_SOF) return 1'b0;
      end
    return 1'b1;
  endfunction

  task automatic build(input logic [6:0] d, input logic [6:0] s, input int lenf,
                       input int nd, input int seed, input bit bad);
    logic [15:0] c;
    for (int t = 0; t < 64; t++) begin
      used_src = s + 7'(t);
      fb[0] = C_SOF; fb[1] = {1'b0, d}; fb[2] = {1'b0, used_src}; fb[3] = 8'(lenf);
      for (int k = 0; k < nd; k++) fb[4 + k] = dbyte(seed, k);
      c = 16'hFFFF;
      for (int i = 1; i < 4 + nd; i++) c = crc_bits(c, fb[i]);
      if (bad) c = c ^ 16'h0100;
      fb[4 + nd] = c[15:8]; fb[5 + nd] = c[7:0]; fb[6 + nd] = C_EOF;
      fn = 7 + nd;
      if (seq_clean()) break;
    end
  endtask

  task automatic send_frame();
    for (int i = 0; i < fn; i++) send_byte(fb[i]);
    idle(20);
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      finish_up();
    end
  end

  initial begin
    logic [6:0] dsts [0:2];
    logic [6:0] nas  [0:1];
    nas[0] = 7'h05; nas[1] = 7'h40;
    ok_n = 0; crc_n = 0; ill_n = 0; tok_n = 0; ovl_n = 0; pay_n = 0;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk("R12 flags", int'({frame_ok, crc_err, illegal_seq, token_seen, pay_valid}), 0);
    chk("R12 fields", int'(dest_addr) + int'(src_addr) + int'(frame_len) + int'(chan_num) + int'(trans_num), 0);
    @(negedge clk) rst_n = 1'b1;
    idle(10);

    // R1 R2 R3 R4 R5 R7 R11 sweep
    for (int a = 0; a < 2; a++) begin
      node_addr = nas[a];
      dsts[0] = nas[a]; dsts[1] = 7'h7F; dsts[2] = nas[a] ^ 7'h11;
      for (int ds = 0; ds < 3; ds++)
        for (int ln = 0; ln <= 6; ln++) begin
          int seed;
          bit exp_ok;
          seed = a * 31 + ds * 7 + ln;
          exp_ok = (ds != 2);
          build(dsts[ds], 7'(seed + 3), ln, ln, seed, 1'b0);
          clear();
          idle(seed % 5);
          send_frame();
          chk("R7 accept", ok_n, int'(exp_ok));
          chk("R5 no crc error", crc_n, 0);
          chk("R1 R2 no illegal", ill_n, 0);
          chk("R11 payload count", pay_n, exp_ok ? ln : 0);
          if (exp_ok) begin
            chk("R3 dest", int'(c_dest), int'(dsts[ds]));
            chk("R3 src", int'(c_src), int'(used_src));
            chk("R3 len", int'(c_len), ln);
            chk("R4 chan", int'(c_chan), ln >= 1 ? int'(dbyte(seed, 0)) : 0);
            chk("R4 trans", int'(c_trans), ln >= 2 ? int'(dbyte(seed, 1)) : 0);
            chk("R7 bcast", int'(c_bcast), int'(ds == 1));
            for (int k = 0; k < ln; k++) chk("R11 payload byte", int'(pay_buf[k]), int'(dbyte(seed, k)));
          end
        end
    end
    node_addr = 7'h05;

    // R6 crc mismatch
    build(7'h05, 7'h21, 3, 3, 90, 1'b1);
    clear(); send_frame();
    chk("R6 crc_err", crc_n, 1);
    chk("R6 no accept", ok_n, 0);
    chk("R6 no illegal", ill_n, 0);

    // R8 length field larger than data
    build(7'h05, 7'h22, 3, 2, 91, 1'b0);
    clear(); send_frame();
    chk("R8 short illegal", ill_n, 1);
    chk("R8 short no accept", ok_n, 0);
    // R8 length field smaller than data
    build(7'h05, 7'h23, 1, 2, 92, 1'b0);
    clear(); send_frame();
    chk("R8 long illegal", ill_n, 1);
    chk("R8 long no accept", ok_n + crc_n, 0);
    // R8 recovery
    build(7'h05, 7'h24, 2, 2, 93, 1'b0);
    clear(); send_frame();
    chk("R8 recovery accept", ok_n, 1);

    // R9 token
    clear();
    send_byte(C_SOF); send_byte(C_TOK); send_byte(C_EOF); idle(20);
    chk("R9 token", tok_n, 1);
    chk("R9 token quiet", ok_n + ill_n + pay_n, 0);
    clear();
    send_byte(C_SOF); send_byte(C_TOK); send_byte(8'h11); send_byte(C_EOF); idle(20);
    chk("R9 bad token illegal", ill_n, 1);
    chk("R9 bad token no token", tok_n, 0);

    // R10 start inside a frame, restart on the same strobe
    build(7'h05, 7'h25, 3, 3, 94, 1'b0);
    clear();
    send_byte(C_SOF); send_byte(8'h05); send_byte(8'h12);
    send_frame();
    chk("R10 illegal", ill_n, 1);
    chk("R10 restart accept", ok_n, 1);
    chk("R10 payload count", pay_n, 3);
    for (int k = 0; k < 3; k++) chk("R10 payload byte", int'(pay_buf[k]), int'(dbyte(94, k)));

    chk("R13 flag overlap", ovl_n, 0);
    finished = 1'b1;
    finish_up();
  end
endmodule